// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers a vector of level-sensitive interrupt lines into two processor-facing requests: a normal request and a fast request. Each request has its own enable mask over the same raw level vector, so one source can be steered to either output, to both, or to neither. Software changes a mask only through a pair of write-only registers: one sets the bits written as 1, the other clears them. This lets separate drivers own separate bits without a read-modify-write sequence.

Line 0 also acts as a software interrupt. Software raises or drops it through dedicated set and clear registers. An edge on the hardware input of line 0 updates the same bit, and the most recent event decides its value. The raw levels, the masked status of each output and both masks can be read over a word-addressed register bus. Reads are combinational. Writes take effect at the clock edge. Both request outputs are registered.

Top module: `intc_dual`

## Requirements
- R1: After reset both masks are zero, the raw level is zero, and both request outputs are low.
- R2: For lines 1 and up, the raw level at word offsets 1 and 9 equals the input levels sampled at the most recent clock edge.
- R3: The normal request output is high exactly when the raw level ANDed with the normal mask is nonzero. It follows a change of input or mask one clock edge later.
- R4: The fast request output is high exactly when the raw level ANDed with the fast mask is nonzero. It is independent of the normal mask.
- R5: A write to offset 2 (normal) or offset 10 (fast) ORs the data into that mask. A read of the same offset returns the mask.
- R6: A write to offset 3 (normal) or offset 11 (fast) clears every mask bit written as 1 and leaves the other bits unchanged.
- R7: A write with data bit 0 set to offset 4 sets level bit 0, and one to offset 5 clears it. A write with data bit 0 at zero does nothing. A read of offset 4 returns level bit 0 in bit 0, with all other bits zero.
- R8: Level bit 0 takes the new value of hardware input 0 whenever that input changes, and otherwise keeps the last value software wrote. When a software write and an input change land on the same edge, the software write wins.
- R9: A read of offset 0 returns the raw level ANDed with the normal mask. A read of offset 8 returns the raw level ANDed with the fast mask.
- R10: Writes to offsets 0, 1, 8, 9 and to unmapped offsets change nothing. Reads of offsets 3, 5, 11 and of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, acts at the clock edge |
| bus_addr | input | ADDR_W | Word offset of the register |
| bus_wdata | input | NUM_LINES | Write data |
| bus_rdata | output | NUM_LINES | Combinational read data for bus_addr |
| irq_lines | input | NUM_LINES | Level-sensitive interrupt inputs |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |

## Verification
A corrupted mask bit or level bit shows at the ports within one clock edge. A read of offset 2 or 10 exposes the mask directly. The request outputs and the masked status reads disagree as soon as any line covered by that bit is active. Sweeping one active line at a time across complementary mask patterns therefore exposes any swapped, stuck or crossed bit between the two outputs. Line 0 needs event sequences rather than steady levels, because a stale edge detector only shows up as a wrong value at offset 4 after a software write followed by a held or changing input.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // Register word offsets; the bus master decodes these, so they are fixed.
  localparam int OFF_IRQ_STAT  = 0;
  localparam int OFF_RAW       = 1;
  localparam int OFF_IRQ_SET   = 2;
  localparam int OFF_IRQ_CLR   = 3;
  localparam int OFF_SOFT_SET  = 4;
  localparam int OFF_SOFT_CLR  = 5;
  localparam int OFF_FIQ_STAT  = 8;
  localparam int OFF_FIQ_RAW   = 9;
  localparam int OFF_FIQ_SET   = 10;
  localparam int OFF_FIQ_CLR   = 11;
  localparam int MIN_ADDR_W    = 4;

  typedef struct packed {
    logic irq_set;
    logic irq_clr;
    logic fiq_set;
    logic fiq_clr;
    logic soft_set;
    logic soft_clr;
  } wr_strobe_t;
endpackage

// File: rtl/intc_decode.sv
module intc_decode
  import intc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wdata_lsb,
  output wr_strobe_t        strobe
);
  always_comb begin
    strobe          = '0;
    strobe.irq_set  = wr_en && (addr == ADDR_W'(OFF_IRQ_SET));
    strobe.irq_clr  = wr_en && (addr == ADDR_W'(OFF_IRQ_CLR));
    strobe.fiq_set  = wr_en && (addr == ADDR_W'(OFF_FIQ_SET));
    strobe.fiq_clr  = wr_en && (addr == ADDR_W'(OFF_FIQ_CLR));
    strobe.soft_set = wr_en && wdata_lsb && (addr == ADDR_W'(OFF_SOFT_SET));
    strobe.soft_clr = wr_en && wdata_lsb && (addr == ADDR_W'(OFF_SOFT_CLR));
  end
endmodule

// File: rtl/intc_mask_reg.sv
module intc_mask_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] mask_d,
  output logic [WIDTH-1:0] mask_q
);
  logic upd_en;

  always_comb begin
    upd_en = set_en | clr_en;
    mask_d = mask_q;
    if (set_en)      mask_d = mask_q | wdata;
    else if (clr_en) mask_d = mask_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_q <= '0;
    else if (upd_en) mask_q <= mask_d;
  end

  assert_set_or_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((mask_q & $past(wdata)) == $past(wdata)));
  assert_keep_others_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((mask_q & ~$past(wdata)) == ($past(mask_q) & ~$past(wdata))));
  assert_clr_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> ((mask_q & $past(wdata)) == '0));
  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(mask_q));
endmodule

// File: rtl/intc_level_capture.sv
module intc_level_capture #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines_i,
  input  logic                 soft_set,
  input  logic                 soft_clr,
  output logic [NUM_LINES-1:0] level_d,
  output logic [NUM_LINES-1:0] level_q
);
  logic line0_prev_q;
  logic line0_evt;
  logic bit0_d;

  // Line 0: software write beats a same-edge hardware change.
  always_comb begin
    line0_evt = lines_i[0] ^ line0_prev_q;
    bit0_d    = level_q[0];
    if (soft_set)       bit0_d = 1'b1;
    else if (soft_clr)  bit0_d = 1'b0;
    else if (line0_evt) bit0_d = lines_i[0];
  end

  always_comb level_d[0] = bit0_d;

  generate
    if (NUM_LINES > 1) begin : g_upper
      always_comb level_d[NUM_LINES-1:1] = lines_i[NUM_LINES-1:1];

      assert_upper_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (level_q[NUM_LINES-1:1] == $past(lines_i[NUM_LINES-1:1])));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q      <= '0;
      line0_prev_q <= 1'b0;
    end else begin
      level_q      <= level_d;
      line0_prev_q <= lines_i[0];
    end
  end

  assert_soft_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_set |=> level_q[0]);
  assert_soft_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_clr && !soft_set) |=> !level_q[0]);
endmodule

// File: rtl/intc_read_mux.sv
module intc_read_mux
  import intc_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_LINES = 32
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_LINES-1:0] level_q,
  input  logic [NUM_LINES-1:0] irq_mask_q,
  input  logic [NUM_LINES-1:0] fiq_mask_q,
  output logic [NUM_LINES-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFF_IRQ_STAT))      rdata = level_q & irq_mask_q;
    else if (addr == ADDR_W'(OFF_RAW))      rdata = level_q;
    else if (addr == ADDR_W'(OFF_IRQ_SET))  rdata = irq_mask_q;
    else if (addr == ADDR_W'(OFF_SOFT_SET)) rdata = {{(NUM_LINES-1){1'b0}}, level_q[0]};
    else if (addr == ADDR_W'(OFF_FIQ_STAT)) rdata = level_q & fiq_mask_q;
    else if (addr == ADDR_W'(OFF_FIQ_RAW))  rdata = level_q;
    else if (addr == ADDR_W'(OFF_FIQ_SET))  rdata = fiq_mask_q;
  end
endmodule

// File: rtl/intc_dual.sv
module intc_dual
  import intc_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr_en,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [NUM_LINES-1:0] bus_wdata,
  output logic [NUM_LINES-1:0] bus_rdata,
  input  logic [NUM_LINES-1:0] irq_lines,
  output logic                 irq_o,
  output logic                 fiq_o
);
  localparam int ADDR_OK = (ADDR_W >= MIN_ADDR_W) ? 1 : 0;

  wr_strobe_t           strobe;
  logic [NUM_LINES-1:0] level_d, level_q;
  logic [NUM_LINES-1:0] irq_mask_d, irq_mask_q;
  logic [NUM_LINES-1:0] fiq_mask_d, fiq_mask_q;
  logic                 irq_d, fiq_d;

  initial begin
    assert (ADDR_OK == 1) else $error("ADDR_W too small for register map");
    assert (NUM_LINES >= 2) else $error("NUM_LINES must be at least 2");
  end

  intc_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wr_en     (bus_wr_en),
    .addr      (bus_addr),
    .wdata_lsb (bus_wdata[0]),
    .strobe    (strobe)
  );

  intc_level_capture #(.NUM_LINES(NUM_LINES)) u_level (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines_i  (irq_lines),
    .soft_set (strobe.soft_set),
    .soft_clr (strobe.soft_clr),
    .level_d  (level_d),
    .level_q  (level_q)
  );

  intc_mask_reg #(.WIDTH(NUM_LINES)) u_irq_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (strobe.irq_set),
    .clr_en (strobe.irq_clr),
    .wdata  (bus_wdata),
    .mask_d (irq_mask_d),
    .mask_q (irq_mask_q)
  );

  intc_mask_reg #(.WIDTH(NUM_LINES)) u_fiq_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (strobe.fiq_set),
    .clr_en (strobe.fiq_clr),
    .wdata  (bus_wdata),
    .mask_d (fiq_mask_d),
    .mask_q (fiq_mask_q)
  );

  intc_read_mux #(.ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES)) u_rmux (
    .addr       (bus_addr),
    .level_q    (level_q),
    .irq_mask_q (irq_mask_q),
    .fiq_mask_q (fiq_mask_q),
    .rdata      (bus_rdata)
  );

  // Requests are computed from next-state values so they line up with status.
  always_comb begin
    irq_d = |(level_d & irq_mask_d);
    fiq_d = |(level_d & fiq_mask_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= irq_d;
      fiq_o <= fiq_d;
    end
  end

  assert_irq_matches_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == |(level_q & irq_mask_q));
  assert_fiq_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o == |(level_q & fiq_mask_q));
  assert_one_mask_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({strobe.irq_set, strobe.irq_clr, strobe.fiq_set, strobe.fiq_clr,
                strobe.soft_set, strobe.soft_clr}) <= 1);
endmodule

// File: tb/test_intc_dual.sv
module test_intc_dual;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 32;
  localparam int AW         = 4;

  logic          clk;
  logic          rst_n;
  logic          bus_wr_en;
  logic [AW-1:0] bus_addr;
  logic [N-1:0]  bus_wdata;
  logic [N-1:0]  bus_rdata;
  logic [N-1:0]  irq_lines;
  logic          irq_o;
  logic          fiq_o;

  int checks;
  int fails;
  bit finished;

  logic [N-1:0] m_irq;
  logic [N-1:0] m_fiq;
  logic         m_lvl0;

  intc_dual #(.NUM_LINES(N), .ADDR_W(AW)) i_intc_dual (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_lines (irq_lines),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [N-1:0] exp_level();
    return {irq_lines[N-1:1], m_lvl0};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [N-1:0] d);
    bus_addr = AW'(a);
    #1;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [N-1:0] exp);
    logic [N-1:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  // Write one register; the model applies the register semantics.
  task automatic wr(input int a, input logic [N-1:0] d);
    bus_addr  = AW'(a);
    bus_wdata = d;
    bus_wr_en = 1'b1;
    tick();
    bus_wr_en = 1'b0;
    case (a)
      2:  m_irq = m_irq | d;
      3:  m_irq = m_irq & ~d;
      4:  if (d[0]) m_lvl0 = 1'b1;
      5:  if (d[0]) m_lvl0 = 1'b0;
      10: m_fiq = m_fiq | d;
      11: m_fiq = m_fiq & ~d;
      default: ;
    endcase
  endtask

  task automatic drive_lines(input logic [N-1:0] v);
    if (v[0] != irq_lines[0]) m_lvl0 = v[0];
    irq_lines = v;
    tick();
  endtask

  task automatic check_all(input string tag);
    logic [N-1:0] lv;
    lv = exp_level();
    chk({tag, " R3 irq_o"}, N'(irq_o), N'(|(lv & m_irq)));
    chk({tag, " R4 fiq_o"}, N'(fiq_o), N'(|(lv & m_fiq)));
    rd_chk({tag, " R2 raw@1"}, 1, lv);
    rd_chk({tag, " R2 raw@9"}, 9, lv);
    rd_chk({tag, " R9 irq stat"}, 0, lv & m_irq);
    rd_chk({tag, " R9 fiq stat"}, 8, lv & m_fiq);
    rd_chk({tag, " R5 irq mask"}, 2, m_irq);
    rd_chk({tag, " R5 fiq mask"}, 10, m_fiq);
    rd_chk({tag, " R7 soft rd"}, 4, N'(lv[0]));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pat [4];
    checks = 0; fails = 0; finished = 1'b0;
    m_irq = '0; m_fiq = '0; m_lvl0 = 1'b0;
    rst_n = 1'b0; bus_wr_en = 1'b0; bus_addr = '0; bus_wdata = '0; irq_lines = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 irq_o", N'(irq_o), '0);
    chk("R1 fiq_o", N'(fiq_o), '0);
    rd_chk("R1 irq mask", 2, '0);
    rd_chk("R1 fiq mask", 10, '0);
    rd_chk("R1 raw", 1, '0);

    // R5 / R6: OR-accumulate and selective clear on both masks
    pat[0] = 32'h0000_00F0; pat[1] = 32'h1234_0001; pat[2] = 32'h8000_0000; pat[3] = 32'h00FF_FF00;
    for (int k = 0; k < 4; k++) begin
      wr(2, pat[k]);
      rd_chk("R5 irq set accum", 2, m_irq);
      wr(10, ~pat[k]);
      rd_chk("R5 fiq set accum", 10, m_fiq);
    end
    for (int k = 0; k < 4; k++) begin
      wr(3, pat[k]);
      rd_chk("R6 irq clear", 2, m_irq);
      wr(11, pat[k] << 1);
      rd_chk("R6 fiq clear", 10, m_fiq);
    end
    wr(3, '1); wr(11, '1);
    rd_chk("R6 irq all clear", 2, '0);
    rd_chk("R6 fiq all clear", 10, '0);

    // R2 R3 R4 R9: walk one active line under several mask pairs
    pat[0] = 32'h5555_5555; pat[1] = 32'hFFFF_0000; pat[2] = 32'h0000_0000; pat[3] = 32'hFFFF_FFFF;
    for (int k = 0; k < 4; k++) begin
      wr(3, '1); wr(11, '1);
      wr(2, pat[k]);
      wr(10, ~pat[k]);
      for (int i = 0; i < N; i++) begin
        drive_lines(N'(1) << i);
        check_all("walk");
      end
      drive_lines('0);
      check_all("idle");
    end

    // R3: mask change with a held level moves the output one edge later
    wr(3, '1); wr(11, '1);
    drive_lines(32'h0000_0100);
    chk("R3 masked off", N'(irq_o), '0);
    wr(2, 32'h0000_0100);
    chk("R3 mask on next edge", N'(irq_o), 1);
    chk("R4 fiq unaffected", N'(fiq_o), '0);
    wr(10, 32'h0000_0100);
    chk("R4 fiq on next edge", N'(fiq_o), 1);
    wr(3, 32'h0000_0100);
    chk("R3 mask off next edge", N'(irq_o), '0);
    chk("R4 fiq stays", N'(fiq_o), 1);
    drive_lines('0);
    check_all("after mask");

    // R7: software line 0
    wr(3, '1); wr(11, '1); wr(2, 32'h1); wr(10, 32'h1);
    wr(4, 32'h2);
    rd_chk("R7 bit0 zero no set", 4, '0);
    wr(4, 32'hFFFF_FFFF);
    rd_chk("R7 soft set", 4, 32'h1);
    check_all("R7 set");
    wr(5, 32'hFFFF_FFFE);
    rd_chk("R7 bit0 zero no clear", 4, 32'h1);
    wr(5, 32'h1);
    rd_chk("R7 soft clear", 4, '0);
    check_all("R7 clr");

    // R8: most recent event wins on line 0
    drive_lines(32'h1);
    rd_chk("R8 hw rise", 4, 32'h1);
    wr(5, 32'h1);
    rd_chk("R8 sw clear over held hw", 4, '0);
    tick(); tick();
    rd_chk("R8 held hw no re-set", 4, '0);
    chk("R8 irq stays low", N'(irq_o), '0);
    wr(4, 32'h1);
    drive_lines(32'h0);
    rd_chk("R8 hw fall after sw set", 4, '0);
    // same-edge: hardware rises while software clears
    bus_addr = AW'(5); bus_wdata = 32'h1; bus_wr_en = 1'b1; irq_lines = 32'h1;
    tick();
    bus_wr_en = 1'b0; m_lvl0 = 1'b0;
    rd_chk("R8 same edge sw wins", 4, '0);
    chk("R8 same edge irq", N'(irq_o), '0);
    // same-edge: hardware falls while software sets
    bus_addr = AW'(4); bus_wdata = 32'h1; bus_wr_en = 1'b1; irq_lines = 32'h0;
    tick();
    bus_wr_en = 1'b0; m_lvl0 = 1'b1;
    rd_chk("R8 same edge sw set wins", 4, 32'h1);
    chk("R8 same edge fiq", N'(fiq_o), 1);
    wr(5, 32'h1);
    check_all("R8 end");

    // R10: ignored writes and zero reads
    wr(3, '1); wr(11, '1); wr(2, 32'h0F0F_0F0F); wr(10, 32'hF0F0_0000);
    drive_lines(32'h0101_0100);
    for (int a = 0; a < 16; a++) begin
      if (a != 2 && a != 3 && a != 4 && a != 5 && a != 10 && a != 11) begin
        wr(a, '1);
        check_all("R10 ignored write");
      end
    end
    rd_chk("R10 read irq clr", 3, '0);
    rd_chk("R10 read soft clr", 5, '0);
    rd_chk("R10 read fiq clr", 11, '0);
    for (int a = 12; a < 16; a++) rd_chk("R10 read unmapped", a, '0);
    rd_chk("R10 read unmapped 6", 6, '0);
    rd_chk("R10 read unmapped 7", 7, '0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule